// File: doc/BRIEF.md
# Serial Stereo Gain Trim Writer

This block programs an external two-channel gain/trim device whose select, serial-clock and serial-data pins are not driven directly. They are three bit positions inside a wider control word, and a separate latch loader pushes that word out to the board. The block takes a 16-bit gain value and a base control word. It then produces the complete run of control words that selects the device, shifts the gain in and deselects it. Every word goes out as one request to the latch loader, and the block waits for that request to be acknowledged before it moves on.

The gain value holds two 8-bit channel fields: bits 15:8 for one channel and bits 7:0 for the other. The device select is active low. The select word is written twice back to back so that the device hold time is met. Every gain bit costs three complete transfers: data, clock high, clock low. With the default widths a full programming run is 2 + 3*16 + 1 = 51 transfers. The bit positions, gain width, select repeat count and select polarity are all parameters.

Top module: `gain_trim_writer`

## Requirements
- R1: After reset, `xfer_req_o`, `busy_o` and `done_o` are low and `xfer_word_o` is zero.
- R2: A `start_i` pulse while idle captures `gain_i` and `base_i`, and `busy_o` is high on the following cycle. A `start_i` pulse, or a change of `gain_i` or `base_i`, while busy has no effect on the words of the run in progress.
- R3: The first two words of a run equal the base word with bit 6 (device select, active low) cleared.
- R4: Gain bits are sent from bit 15 down to bit 0. Each bit produces three words. The data word is the base word with bits 6, 7 and 8 cleared and bit 8 set to the gain bit. The clock word is the data word with bit 7 (serial clock) set. The third word equals the data word.
- R5: The last word of a run is the base word unmodified, so bit 6 takes the base value again. A run holds exactly 51 words.
- R6: In every word, all bits other than 6, 7 and 8 equal the corresponding bits of the captured base word.
- R7: Once `xfer_req_o` rises, it stays high and `xfer_word_o` stays stable until `xfer_ack_i` is sampled high. On the cycle after an acknowledge, `xfer_req_o` is low.
- R8: `done_o` pulses high for exactly one cycle after the final word is acknowledged. In that cycle `busy_o` and `xfer_req_o` are low, and a new `start_i` is accepted afterwards.
- R9: The word sequence does not depend on how many cycles the acknowledge takes.
- R10: The run never launches a new word while the previous request is still outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a programming run (sampled while idle) |
| gain_i | input | 16 | Gain value, two 8-bit channel fields |
| base_i | input | 20 | Base control word |
| xfer_ack_i | input | 1 | Latch loader has taken the current word |
| xfer_req_o | output | 1 | Word transfer request to the latch loader |
| xfer_word_o | output | 20 | Control word to transfer |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The hardest situation to reach from the ports is a second start, with different gain and base values, arriving in the middle of a run while a word is still waiting for its acknowledge. The bench models the latch loader with an acknowledge delay it can set, counts accepted words, and raises a start with inverted inputs right after the twentieth acknowledge. It then compares all 51 words with the original values. Base words with the select, clock and data bits already set check that those three bits are overridden and that every other bit passes through. Single-bit gains at both ends check the ordering.

// File: rtl/gtw_pkg.sv
package gtw_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_SELECT  = 3'd1,
      PH_DATA    = 3'd2,
      PH_CLK_HI  = 3'd3,
      PH_CLK_LO  = 3'd4,
      PH_RELEASE = 3'd5
   } gtw_phase_e;

   localparam logic [15:0] GTW_DEFAULT_GAIN = 16'hC4C4;

endpackage

// File: rtl/gtw_sequencer.sv
module gtw_sequencer
   import gtw_pkg::*;
#(
   parameter int GAIN_W     = 16,
   parameter int SEL_REPEAT = 2,
   localparam int BIT_IDX_W = (GAIN_W > 1) ? $clog2(GAIN_W) : 1,
   localparam int SEL_W     = (SEL_REPEAT > 1) ? $clog2(SEL_REPEAT) : 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 step_done,
   output gtw_phase_e           phase_o,
   output logic [BIT_IDX_W-1:0] bit_idx_o,
   output logic                 finish_o
);

   localparam logic [SEL_W-1:0]     SEL_LAST = SEL_W'(SEL_REPEAT - 1);
   localparam logic [BIT_IDX_W-1:0] BIT_TOP  = BIT_IDX_W'(GAIN_W - 1);

   gtw_phase_e           phase_q;
   logic [SEL_W-1:0]     sel_cnt_q;
   logic [BIT_IDX_W-1:0] bit_cnt_q;
   logic                 finish_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         sel_cnt_q <= '0;
         bit_cnt_q <= '0;
         finish_q  <= 1'b0;
      end else begin
         finish_q <= 1'b0;
         case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  phase_q   <= PH_SELECT;
                  sel_cnt_q <= '0;
               end
            end
            PH_SELECT: begin
               if (step_done) begin
                  if (sel_cnt_q == SEL_LAST) begin
                     phase_q   <= PH_DATA;
                     bit_cnt_q <= BIT_TOP;
                  end else begin
                     sel_cnt_q <= sel_cnt_q + 1'b1;
                  end
               end
            end
            PH_DATA: begin
               if (step_done) phase_q <= PH_CLK_HI;
            end
            PH_CLK_HI: begin
               if (step_done) phase_q <= PH_CLK_LO;
            end
            PH_CLK_LO: begin
               if (step_done) begin
                  if (bit_cnt_q == '0) begin
                     phase_q <= PH_RELEASE;
                  end else begin
                     bit_cnt_q <= bit_cnt_q - 1'b1;
                     phase_q   <= PH_DATA;
                  end
               end
            end
            PH_RELEASE: begin
               if (step_done) begin
                  phase_q  <= PH_IDLE;
                  finish_q <= 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase_o   = phase_q;
   assign bit_idx_o = bit_cnt_q;
   assign finish_o  = finish_q;

   // R4: the bit counter only moves down by one on a clock-low completion
   p_bit_descend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CLK_LO && step_done && bit_cnt_q != '0) |=> (bit_cnt_q == $past(bit_cnt_q) - 1'b1))
      else $error("bit index did not step down");

endmodule

// File: rtl/gtw_word_build.sv
module gtw_word_build
   import gtw_pkg::*;
#(
   parameter int CTRL_W        = 20,
   parameter int CS_BIT        = 6,
   parameter int SCLK_BIT      = 7,
   parameter int SDATA_BIT     = 8,
   parameter bit CS_ACTIVE_LOW = 1'b1
)(
   input  gtw_phase_e        phase,
   input  logic              data_bit,
   input  logic [CTRL_W-1:0] base,
   output logic [CTRL_W-1:0] word_o
);

   localparam logic [CTRL_W-1:0] CS_M   = CTRL_W'(1) << CS_BIT;
   localparam logic [CTRL_W-1:0] SCLK_M = CTRL_W'(1) << SCLK_BIT;
   localparam logic [CTRL_W-1:0] SDAT_M = CTRL_W'(1) << SDATA_BIT;

   logic [CTRL_W-1:0] sel_word;
   logic [CTRL_W-1:0] bit_word;

   generate
      if (CS_ACTIVE_LOW) begin : g_cs_low
         assign sel_word = base & ~CS_M;
         assign bit_word = (base & ~(CS_M | SCLK_M | SDAT_M))
                           | (data_bit ? SDAT_M : '0);
      end else begin : g_cs_high
         assign sel_word = base | CS_M;
         assign bit_word = ((base & ~(SCLK_M | SDAT_M)) | CS_M)
                           | (data_bit ? SDAT_M : '0);
      end
   endgenerate

   always_comb begin
      case (phase)
         PH_SELECT:  word_o = sel_word;
         PH_DATA:    word_o = bit_word;
         PH_CLK_HI:  word_o = bit_word | SCLK_M;
         PH_CLK_LO:  word_o = bit_word;
         PH_RELEASE: word_o = base;
         default:    word_o = base;
      endcase
   end

endmodule

// File: rtl/gtw_xfer_port.sv
module gtw_xfer_port #(
   parameter int CTRL_W = 20
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [CTRL_W-1:0] word_in,
   input  logic              ack,
   output logic              req_o,
   output logic [CTRL_W-1:0] word_o,
   output logic              step_done_o
);

   logic              req_q;
   logic [CTRL_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         word_q <= '0;
      end else if (req_q && ack) begin
         req_q <= 1'b0;
      end else if (active && !req_q) begin
         req_q  <= 1'b1;
         word_q <= word_in;
      end
   end

   assign req_o       = req_q;
   assign word_o      = word_q;
   assign step_done_o = req_q && ack;

   // R7: an outstanding request holds its word until acknowledged
   p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !ack) |=> (req_q && $stable(word_q)))
      else $error("request or word changed before acknowledge");

   // R7: request drops right after an acknowledge
   p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && ack) |=> !req_q)
      else $error("request still high after acknowledge");

endmodule

// File: rtl/gain_trim_writer.sv
module gain_trim_writer
   import gtw_pkg::*;
#(
   parameter int CTRL_W        = 20,
   parameter int GAIN_W        = 16,
   parameter int CS_BIT        = 6,
   parameter int SCLK_BIT      = 7,
   parameter int SDATA_BIT     = 8,
   parameter int SEL_REPEAT    = 2,
   parameter bit CS_ACTIVE_LOW = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [GAIN_W-1:0] gain_i,
   input  logic [CTRL_W-1:0] base_i,
   input  logic              xfer_ack_i,
   output logic              xfer_req_o,
   output logic [CTRL_W-1:0] xfer_word_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int BIT_IDX_W = (GAIN_W > 1) ? $clog2(GAIN_W) : 1;
   localparam logic [CTRL_W-1:0] CTL_M = (CTRL_W'(1) << CS_BIT)
                                       | (CTRL_W'(1) << SCLK_BIT)
                                       | (CTRL_W'(1) << SDATA_BIT);
   localparam logic CS_ON = CS_ACTIVE_LOW ? 1'b0 : 1'b1;

   generate
      if (CS_BIT >= CTRL_W || SCLK_BIT >= CTRL_W || SDATA_BIT >= CTRL_W) begin : g_bad_pos
         $error("control bit position outside the control word");
      end
      if (CS_BIT == SCLK_BIT || CS_BIT == SDATA_BIT || SCLK_BIT == SDATA_BIT) begin : g_bad_overlap
         $error("control bit positions must be distinct");
      end
      if (GAIN_W < 1 || SEL_REPEAT < 1) begin : g_bad_count
         $error("gain width and select repeat must be at least one");
      end
   endgenerate

   gtw_phase_e           phase;
   logic [BIT_IDX_W-1:0] bit_idx;
   logic                 step_done;
   logic                 finish;
   logic                 accept;
   logic [GAIN_W-1:0]    gain_q;
   logic [CTRL_W-1:0]    base_q;
   logic [CTRL_W-1:0]    next_word;

   assign accept = start_i && (phase == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_q <= '0;
         base_q <= '0;
      end else if (accept) begin
         gain_q <= gain_i;
         base_q <= base_i;
      end
   end

   gtw_sequencer #(
      .GAIN_W     (GAIN_W),
      .SEL_REPEAT (SEL_REPEAT)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .step_done (step_done),
      .phase_o   (phase),
      .bit_idx_o (bit_idx),
      .finish_o  (finish)
   );

   gtw_word_build #(
      .CTRL_W        (CTRL_W),
      .CS_BIT        (CS_BIT),
      .SCLK_BIT      (SCLK_BIT),
      .SDATA_BIT     (SDATA_BIT),
      .CS_ACTIVE_LOW (CS_ACTIVE_LOW)
   ) u_build (
      .phase    (phase),
      .data_bit (gain_q[bit_idx]),
      .base     (base_q),
      .word_o   (next_word)
   );

   gtw_xfer_port #(
      .CTRL_W (CTRL_W)
   ) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (phase != PH_IDLE),
      .word_in     (next_word),
      .ack         (xfer_ack_i),
      .req_o       (xfer_req_o),
      .word_o      (xfer_word_o),
      .step_done_o (step_done)
   );

   assign busy_o = (phase != PH_IDLE);
   assign done_o = finish;

   // R3: select held active in every word before the release word
   p_cs_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req_o && phase != PH_RELEASE && phase != PH_IDLE) |-> (xfer_word_o[CS_BIT] == CS_ON))
      else $error("select not active during programming");

   // R4: serial clock high only in the clock-high word of a bit
   p_sclk_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req_o && (phase == PH_DATA || phase == PH_CLK_LO)) |-> !xfer_word_o[SCLK_BIT])
      else $error("serial clock high outside its slot");

   // R6: untouched bits follow the captured base word
   p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req_o |-> ((xfer_word_o & ~CTL_M) == (base_q & ~CTL_M)))
      else $error("pass-through bits altered");

   // R8: done pulse coincides with no request outstanding and lasts one cycle
   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!xfer_req_o && !busy_o))
      else $error("done with activity");
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o)
      else $error("done longer than one cycle");

   // R10: no request exists before the run has started
   p_no_early_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !xfer_req_o)
      else $error("request raised before run start");

endmodule

// File: tb/gain_trim_writer_tb.sv
module gain_trim_writer_tb;
   import gtw_pkg::*;

   localparam int NWORDS = 51;
   localparam logic [19:0] CSM = 20'h00040;
   localparam logic [19:0] CKM = 20'h00080;
   localparam logic [19:0] DTM = 20'h00100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] gain_i = '0;
   logic [19:0] base_i = '0;
   logic        xfer_ack_i = 1'b0;
   logic        xfer_req_o;
   logic [19:0] xfer_word_o;
   logic        busy_o;
   logic        done_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   gain_trim_writer u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .gain_i      (gain_i),
      .base_i      (base_i),
      .xfer_ack_i  (xfer_ack_i),
      .xfer_req_o  (xfer_req_o),
      .xfer_word_o (xfer_word_o),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [19:0] exp_word(input int k, input logic [15:0] g, input logic [19:0] b);
      int j;
      logic [19:0] w;
      if (k < 2) return b & ~CSM;
      if (k == NWORDS - 1) return b;
      j = k - 2;
      w = (b & ~(CSM | CKM | DTM)) | (g[15 - j/3] ? DTM : 20'h0);
      if (j % 3 == 1) w = w | CKM;
      return w;
   endfunction

   // Runs one programming sequence acting as the latch loader.
   task automatic run_seq(input logic [15:0] g, input logic [19:0] b, input int delay, input int inject_at);
      logic [19:0] got [0:63];
      logic [19:0] held;
      int n = 0;
      int waitc = 0;
      int cyc = 0;
      bit done_seen = 0;
      bit stable_ok = 1;
      bit pass_ok = 1;
      bit busy_ok = 1;
      @(negedge clk);
      gain_i = g; base_i = b; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o === 1'b1, "R2 busy after start", {31'd0, busy_o}, 32'd1);
      held = '0;
      while (!done_seen && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         if (start_i) start_i = 1'b0;
         if (xfer_ack_i) begin
            xfer_ack_i = 1'b0;
         end else if (xfer_req_o) begin
            if (!busy_o) busy_ok = 0;
            if (waitc == 0) held = xfer_word_o;
            else if (xfer_word_o !== held) stable_ok = 0;
            if (waitc < delay) begin
               waitc++;
            end else begin
               if (n < 64) got[n] = xfer_word_o;
               n++;
               xfer_ack_i = 1'b1;
               waitc = 0;
               if (n == inject_at) begin
                  start_i = 1'b1; gain_i = ~g; base_i = ~b;
               end
            end
         end
         if (done_o) begin
            done_seen = 1;
            chk(!xfer_req_o && !busy_o, "R8 quiet at done", {30'd0, xfer_req_o, busy_o}, 32'd0);
         end
      end
      chk(done_seen, "R8 done pulse seen", {31'd0, done_seen}, 32'd1);
      chk(stable_ok, "R7 word stable while waiting", {31'd0, stable_ok}, 32'd1);
      chk(busy_ok, "R2 busy during run", {31'd0, busy_ok}, 32'd1);
      chk(n == NWORDS, "R5 word count", n, NWORDS);
      for (int k = 0; k < NWORDS && k < n; k++) begin
         if (((got[k] ^ b) & ~(CSM | CKM | DTM)) != 0) pass_ok = 0;
         if (k < 2)
            chk(got[k] == exp_word(k, g, b), "R3 select word", {12'd0, got[k]}, {12'd0, exp_word(k, g, b)});
         else if (k == NWORDS - 1)
            chk(got[k] == exp_word(k, g, b), "R5 release word", {12'd0, got[k]}, {12'd0, exp_word(k, g, b)});
         else
            chk(got[k] == exp_word(k, g, b), "R4 bit word", {12'd0, got[k]}, {12'd0, exp_word(k, g, b)});
      end
      chk(pass_ok, "R6 pass-through bits", {31'd0, pass_ok}, 32'd1);
      @(negedge clk);
      chk(!done_o, "R8 done one cycle", {31'd0, done_o}, 32'd0);
   endtask

   task automatic t_reset();
      chk(!xfer_req_o && !busy_o && !done_o, "R1 reset controls", {29'd0, xfer_req_o, busy_o, done_o}, 32'd0);
      chk(xfer_word_o == 20'h0, "R1 reset word", {12'd0, xfer_word_o}, 32'd0);
   endtask

   task automatic t_default_gain();   // R4 default gain, fast loader (R9)
      run_seq(GTW_DEFAULT_GAIN, 20'h02A30, 0, -1);
   endtask

   task automatic t_msb_only();       // R4 ordering: only bit 15 set
      run_seq(16'h8000, 20'h00000, 2, -1);
   endtask

   task automatic t_lsb_override();   // R4/R6: only bit 0, base with control bits set
      run_seq(16'h0001, 20'hFFFFF, 1, -1);
   endtask

   task automatic t_slow_ack();       // R9 long acknowledge latency
      run_seq(16'h5A3C, 20'h9C1C0, 5, -1);
   endtask

   task automatic t_busy_start();     // R2 start while busy ignored
      run_seq(16'h1234, 20'h4B0C0, 1, 20);
   endtask

   task automatic t_back_to_back();   // R8 restart after done, R10
      run_seq(16'hFFFF, 20'h00000, 0, -1);
      run_seq(16'h0000, 20'hAAAAA, 3, -1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default_gain();
      t_msb_only();
      t_lsb_override();
      t_slow_ack();
      t_busy_start();
      t_back_to_back();
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule